// File: doc/BRIEF.md
# Octal Bidirectional Latched Transceiver

This block passes eight-bit data between two ports, A and B, through two separate banks of storage: one bank carries A toward B, the other carries B toward A. Each direction has three active-low controls. The chip enable qualifies everything on that side. The latch enable opens the bank so that it follows its source port. The output enable lets the bank drive the opposite port. Because each direction has its own bank, a word can be parked in one direction while live data flows through the other.

The tri-state pins are split into an input bus, an output bus and a drive-enable per port. A pad ring or bus model outside the block resolves them. The storage is written on a system clock edge while its gate is open. A combinational bypass makes an open bank look transparent at the output in the same cycle. There is no reset: bank contents are undefined until the first open phase.

Top module: `octal_latched_xcvr`

## Requirements
- R1: With ce_ab_n=0 and le_ab_n=0, the A-to-B bank is transparent: while B is driven, b_out equals a_in in the same cycle.
- R2: With ce_ab_n=1, the A-to-B bank keeps its contents whatever le_ab_n and a_in do.
- R3: When le_ab_n rises with ce_ab_n=0, the bank stores the a_in value it held in the last clock cycle in which the gate was open. Later changes on a_in do not reach b_out.
- R4: b_drv is 1 exactly when ce_ab_n=0 and oe_ab_n=0. While b_drv is 0, b_out is all zeros.
- R5: Changing oe_ab_n only switches the B driver. A stored A-to-B word reappears unchanged on b_out once the driver is enabled again.
- R6: The B-to-A bank behaves as in R1, R2 and R3, using ce_ba_n, le_ba_n and b_in, with its result on a_out.
- R7: a_drv is 1 exactly when ce_ba_n=0 and oe_ba_n=0. While a_drv is 0, a_out is all zeros.
- R8: The two directions are independent: one bank can load or hold while the other drives its port.
- R9: Enabling both drivers at once is a contention condition. The block does not arbitrate it; the environment must never let a_drv and b_drv be 1 together, and the block flags it if they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which an open bank captures its source |
| ce_ab_n | input | 1 | A-to-B chip enable, active low |
| le_ab_n | input | 1 | A-to-B latch enable, active low (low = transparent) |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| ce_ba_n | input | 1 | B-to-A chip enable, active low |
| le_ba_n | input | 1 | B-to-A latch enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_in | input | W | Value seen on port A pins |
| a_out | output | W | Value driven onto port A |
| a_drv | output | 1 | Port A driver enable |
| b_in | input | W | Value seen on port B pins |
| b_out | output | W | Value driven onto port B |
| b_drv | output | 1 | Port B driver enable |

## Verification
Two events can land in the same cycle. In the first, a latch enable rises in the very cycle its source port changes. The stored word must then be the value from the previous open cycle, not the new one. In the second, one bank captures while the other drives its port, and each path must be unaffected by the other. Random control and data patterns provoke both events, with combinations that would enable both drivers filtered out. A bench model of each bank, updated only on open-gate clock edges, gives the expected port values each cycle. Directed sequences repeat the edge-plus-data-change case and the hold-while-driving case with fixed words.

// File: rtl/octal_latched_xcvr.sv
module octal_latched_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         ce_ab_n,
  input  logic         le_ab_n,
  input  logic         oe_ab_n,
  input  logic         ce_ba_n,
  input  logic         le_ba_n,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv
);

  logic         open_ab, open_ba;
  logic [W-1:0] bank_ab, bank_ba;
  logic [W-1:0] view_ab, view_ba;

  assign open_ab = ~(ce_ab_n | le_ab_n);
  assign open_ba = ~(ce_ba_n | le_ba_n);

  always_ff @(posedge clk) begin
    if (open_ab) bank_ab <= a_in;
    if (open_ba) bank_ba <= b_in;
  end

  assign view_ab = open_ab ? a_in : bank_ab;
  assign view_ba = open_ba ? b_in : bank_ba;

  assign b_drv = ~(ce_ab_n | oe_ab_n);
  assign a_drv = ~(ce_ba_n | oe_ba_n);
  assign b_out = b_drv ? view_ab : '0;
  assign a_out = a_drv ? view_ba : '0;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_hold_ce_r2: assert property (@(posedge clk) disable iff (!armed)
    ce_ab_n |=> $stable(bank_ab));
  p_hold_le_r3: assert property (@(posedge clk) disable iff (!armed)
    le_ab_n |=> $stable(bank_ab));
  p_follow_r1: assert property (@(posedge clk) disable iff (!armed)
    (!ce_ab_n && !le_ab_n && !oe_ab_n) |-> (b_out == a_in));
  p_quiet_b_r4: assert property (@(posedge clk) disable iff (!armed)
    (ce_ab_n || oe_ab_n) |-> (b_out == '0 && !b_drv));
  p_hold_ba_r6: assert property (@(posedge clk) disable iff (!armed)
    (ce_ba_n || le_ba_n) |=> $stable(bank_ba));
  p_quiet_a_r7: assert property (@(posedge clk) disable iff (!armed)
    (ce_ba_n || oe_ba_n) |-> (a_out == '0 && !a_drv));
  p_no_contention_r9: assert property (@(posedge clk) disable iff (!armed)
    !(a_drv && b_drv));

endmodule

// File: tb/octal_latched_xcvr_tb.sv
module octal_latched_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ce_ab_n = 1, le_ab_n = 1, oe_ab_n = 1;
  logic ce_ba_n = 1, le_ba_n = 1, oe_ba_n = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drv, b_drv;

  octal_latched_xcvr #(.W(W)) dut_i (
    .clk(clk), .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv));

  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] m_ab, m_ba;
  bit v_ab = 0, v_ba = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_view(logic open, logic [W-1:0] src, logic [W-1:0] m);
    return open ? src : m;
  endfunction

  // check outputs against the model, then commit the model as the clock edge will
  task automatic cycle_check(string tag);
    logic oab, oba, eb, ea;
    #1;
    oab = !(ce_ab_n | le_ab_n);
    oba = !(ce_ba_n | le_ba_n);
    eb = !(ce_ab_n | oe_ab_n);
    ea = !(ce_ba_n | oe_ba_n);
    if (eb && ea) begin
      failures++;
      $display("FAIL R9 both drivers enabled actual=1 expected=0");
    end
    chk({"R4 ", tag}, b_drv, eb);
    chk({"R7 ", tag}, a_drv, ea);
    if (!eb) chk({"R4 ", tag}, b_out, 0);
    else if (oab || v_ab) chk({"R1 R3 ", tag}, b_out, exp_view(oab, a_in, m_ab));
    if (!ea) chk({"R7 ", tag}, a_out, 0);
    else if (oba || v_ba) chk({"R6 ", tag}, a_out, exp_view(oba, b_in, m_ba));
    if (oab) begin m_ab = a_in; v_ab = 1; end
    if (oba) begin m_ba = b_in; v_ba = 1; end
    @(negedge clk);
  endtask

  task automatic set_ab(logic ce, logic le, logic oe);
    ce_ab_n = ce; le_ab_n = le; oe_ab_n = oe;
  endtask
  task automatic set_ba(logic ce, logic le, logic oe);
    ce_ba_n = ce; le_ba_n = le; oe_ba_n = oe;
  endtask

  initial begin
    int unsigned seed = 32'h1234_5678;
    void'($urandom(seed));
    @(negedge clk);
    // drivers idle at start
    cycle_check("idle");

    // R1: transparent pass A to B
    set_ab(0, 0, 0); a_in = 8'h3C; cycle_check("R1 pass");
    a_in = 8'hC3; cycle_check("R1 follow");
    // R3: le rises in the same cycle A changes
    le_ab_n = 1; a_in = 8'hFF; cycle_check("R3 edge");
    chk("R3 stored", b_out, 8'hC3);
    for (int i = 0; i < 4; i++) begin a_in = 8'(i * 37); cycle_check("R3 hold"); end
    chk("R3 held", b_out, 8'hC3);
    // R5: toggle output enable
    oe_ab_n = 1; cycle_check("R5 off");
    chk("R5 tristate", b_out, 0);
    oe_ab_n = 0; cycle_check("R5 on");
    chk("R5 restored", b_out, 8'hC3);
    // R2: chip enable high blocks loading even with le low
    set_ab(1, 0, 1); a_in = 8'h11; cycle_check("R2 blocked");
    a_in = 8'h22; cycle_check("R2 blocked");
    set_ab(0, 1, 0); cycle_check("R2 view");
    chk("R2 held", b_out, 8'hC3);

    // R6/R8: B-to-A loads while A-to-B drives B
    set_ab(0, 1, 0); set_ba(0, 0, 1); b_in = 8'h5A; cycle_check("R8 load");
    le_ba_n = 1; b_in = 8'h00; cycle_check("R8 store");
    chk("R8 ab unaffected", b_out, 8'hC3);
    set_ab(0, 1, 1); oe_ba_n = 0; cycle_check("R6 drive");
    chk("R6 stored", a_out, 8'h5A);
    // R8: A-to-B transparent while B-to-A drives its stored word
    le_ab_n = 0; a_in = 8'h77; cycle_check("R8 both");
    chk("R8 ba unaffected", a_out, 8'h5A);
    set_ba(1, 1, 1); set_ab(0, 1, 0); cycle_check("R8 ab");
    chk("R8 ab latched", b_out, 8'h77);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] c;
      c = 6'($urandom());
      set_ab(c[0] & c[1], c[2], c[3] & c[1]);
      set_ba(c[4] & c[5], $urandom_range(0, 1), $urandom_range(0, 1));
      if (!(ce_ab_n | oe_ab_n)) oe_ba_n = 1;
      a_in = 8'($urandom()); b_in = 8'($urandom());
      cycle_check("random");
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule